// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-mapped master for the two-wire PHY management bus. Software sets a mode-enable bit and a clock divider. It then writes one complete 32-bit clause-22 frame (start code, opcode, PHY address, register address, turnaround and data) into a single frame register. The engine first drives a preamble of ones on the data line. It then shifts the frame out exactly as written, most significant bit first, and produces the management clock from the system clock.

For a read frame the master lets go of the data line from the second turnaround bit onward. It samples the sixteen reply bits on rising clock edges and places them in the low half of the same frame register. When a frame ends, a sticky done flag is set in the event register and drives an interrupt line. Software clears the flag by writing a one to it. A busy flag in the same register shows that a frame is in flight.

Register word addresses: 0 is control (bit 0 enables management mode). 1 is speed (divider in bits 6:1). 2 is event (bit 0 is done, write-one-to-clear; bit 1 is busy, read-only). 3 is the frame register.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset every register reads zero, and mdc, mdio_oe and mgmt_irq are low.
- R2: A write to address 3 while control bit 0 is set and no frame is active stores the word and raises busy (event bit 1) on the next cycle.
- R3: On the wire the master presents 32 ones and then the 32 frame bits from bit 31 down to bit 0, one bit per MDC period. While MDC is high, mdio_o does not change.
- R4: With a divider value D of 1 to 63, MDC is high for D system clocks and low for D system clocks, giving a period of 2*D.
- R5: For a frame whose bits 29:28 equal 2'b10 (a read), mdio_oe is low from frame bit 16 (the second turnaround bit) through bit 0. For any other opcode, mdio_oe stays high for all 64 bits. mdio_oe is low whenever no frame is active.
- R6: When a read frame completes, bits 15:0 of the frame register hold the 16 bits sampled from mdio_i on the last 16 rising MDC edges, first sample in bit 15. Bits 31:16 are unchanged. A non-read frame leaves the register unchanged.
- R7: When a frame completes, busy clears and event bit 0 (done) is set in the same cycle. mgmt_irq equals the done bit.
- R8: Writing 1 to event bit 0 clears done. Writing 0 leaves it set.
- R9: While the divider is zero, MDC holds its level and a started frame makes no progress. After a nonzero divider is written, the frame continues and completes normally.
- R10: A frame-register write while busy is ignored. The register contents and the frame on the wire are unaffected.
- R11: A frame-register write while control bit 0 is clear is ignored. No frame starts and the register keeps its old value.
- R12: The speed register reads back only bits 6:1. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mgmt_irq | output | 1 | Done-event interrupt |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the pad |

## Verification
Read and write frames with random PHY addresses, register addresses, payloads and reply words are mixed across several divider values. This separates opcode decoding of the release window from plain bit order and clock timing. Directed cases cover the largest divider, a zero divider that parks a started frame, a frame write made mid-transfer, a write with mode disabled, a done clear written as zero versus one, and speed-register masking. Each case isolates one gating path. A PHY model in the bench rebuilds the wire bit stream and the output-enable pattern at every rising MDC edge and compares them with the expected preamble-plus-frame sequence.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_W = 32;
   localparam int REPLY_W = 16;

   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_SPEED = 2'd1,
      REG_EVENT = 2'd2,
      REG_FRAME = 2'd3
   } reg_sel_e;

   localparam logic [1:0] OP_READ = 2'b10;

   function automatic logic frame_is_read(input logic [FRAME_W-1:0] f);
      return f[29:28] == OP_READ;
   endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] cnt;
   logic             tick;

   assign tick = run && (div != '0) && (cnt >= div - DIV_W'(1));
   assign rise = tick && !mdc;
   assign fall = tick && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (div != '0) begin
         if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
      end
   end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   input  logic               rise,
   input  logic               fall,
   input  logic               mdio_i,
   output logic               busy,
   output logic               finish,
   output logic [REPLY_W-1:0] rx,
   output logic               mdio_o,
   output logic               mdio_oe
);
   localparam int TOT = PRE_LEN + FRAME_W;
   localparam int CW  = $clog2(TOT + 1);

   logic [CW-1:0]      k;
   logic [CW-1:0]      fidx;
   logic [FRAME_W-1:0] frm;
   logic               pre;
   logic               is_rd;
   logic               last;

   generate
      if (PRE_LEN == 0) begin : g_nopre
         assign pre = 1'b0;
      end else begin : g_pre
         assign pre = k < CW'(PRE_LEN);
      end
   endgenerate

   assign fidx   = k - CW'(PRE_LEN);
   assign is_rd  = frame_is_read(frm);
   assign last   = k == CW'(TOT - 1);
   assign finish = busy && fall && last;

   assign mdio_o  = busy ? (pre ? 1'b1 : frm[5'd31 - fidx[4:0]]) : 1'b1;
   assign mdio_oe = busy && !(is_rd && !pre && fidx >= CW'(15));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         k    <= '0;
         frm  <= '0;
         rx   <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         k    <= '0;
         frm  <= frame;
         rx   <= '0;
      end else if (busy) begin
         if (rise && is_rd && !pre && fidx >= CW'(16))
            rx <= {rx[REPLY_W-2:0], mdio_i};
         if (fall) begin
            if (last) busy <= 1'b0;
            else      k    <= k + CW'(1);
         end
      end
   end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int DIV_W   = 6,
   parameter int DIV_LSB = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        mgmt_irq,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (DIV_W < 1 || DIV_LSB + DIV_W > 31) begin : g_bad_div
         $error("divider field does not fit the speed register");
      end
      if (PRE_LEN < 0 || PRE_LEN > 64) begin : g_bad_pre
         $error("preamble length out of range");
      end
   endgenerate

   logic               en_q;
   logic [DIV_W-1:0]   div_q;
   logic               done_q;
   logic [FRAME_W-1:0] frame_q;
   logic               busy;
   logic               finish;
   logic               rise;
   logic               fall;
   logic               start;
   logic [REPLY_W-1:0] rx;

   assign start = bus_wr && (bus_addr == REG_FRAME) && en_q && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         div_q   <= '0;
         done_q  <= 1'b0;
         frame_q <= '0;
      end else begin
         if (bus_wr && bus_addr == REG_CTRL)  en_q  <= bus_wdata[0];
         if (bus_wr && bus_addr == REG_SPEED) div_q <= bus_wdata[DIV_LSB +: DIV_W];
         if (start) frame_q <= bus_wdata;
         else if (finish && frame_is_read(frame_q)) frame_q[REPLY_W-1:0] <= rx;
         if (finish) done_q <= 1'b1;
         else if (bus_wr && bus_addr == REG_EVENT && bus_wdata[0]) done_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_sel_e'(bus_addr))
         REG_CTRL:  bus_rdata = {31'd0, en_q};
         REG_SPEED: bus_rdata = 32'(div_q) << DIV_LSB;
         REG_EVENT: bus_rdata = {30'd0, busy, done_q};
         default:   bus_rdata = frame_q;
      endcase
   end

   assign mgmt_irq = done_q;

   mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
      .mdc(mdc), .rise(rise), .fall(fall)
   );

   mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shf (
      .clk(clk), .rst_n(rst_n), .start(start), .frame(bus_wdata),
      .rise(rise), .fall(fall), .mdio_i(mdio_i),
      .busy(busy), .finish(finish), .rx(rx),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk #(
   parameter int DIV_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic             busy,
   input logic             en_q,
   input logic             done_q,
   input logic [DIV_W-1:0] div_q,
   input logic [31:0]      frame_q,
   input logic             mdc,
   input logic             mdio_o,
   input logic             mdio_oe,
   input logic             mgmt_irq
);
   AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe && !mdc); // R5
   AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> $stable(mdio_o)); // R3
   AST_DIV0_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && div_q == '0) |=> $stable(mdc)); // R9
   AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q); // R7
   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_irq == done_q); // R7
   AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2 && bus_wdata[0] && !busy) |=> !done_q); // R8
   AST_FRAME_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(frame_q[31:16])); // R10
   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3 && !en_q && !busy) |=> !busy); // R11
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .busy(busy), .en_q(en_q), .done_q(done_q),
   .div_q(div_q), .frame_q(frame_q), .mdc(mdc), .mdio_o(mdio_o),
   .mdio_oe(mdio_oe), .mgmt_irq(mgmt_irq)
);

// File: tb/sim_mdio_frame_ctrl.sv
module sim_mdio_frame_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int TOT = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mgmt_irq, mdc, mdio_o, mdio_oe, mdio_i;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   int cyc = 0;

   // PHY model state
   logic        phy_read = 0;
   logic [15:0] phy_reply = '0;
   int          idx = 0;
   int          nrise = 0;
   int          last_rise = 0;
   int          gap_err = 0;
   int          exp_gap = 2;
   int          hi_chg = 0;
   logic        prev_mdc = 0;
   logic        prev_o = 1;
   logic [TOT-1:0] wire_bits;
   logic [TOT-1:0] oe_bits;

   mdio_frame_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mgmt_irq(mgmt_irq),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mdio_i = (phy_read && idx >= 48 && idx < TOT) ? phy_reply[TOT-1-idx] : 1'b1;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (mdc && !prev_mdc) begin
         if (nrise > 0 && cyc - last_rise != exp_gap) gap_err = gap_err + 1;
         last_rise = cyc;
         if (nrise < TOT) begin
            wire_bits[TOT-1-nrise] = mdio_oe ? mdio_o : mdio_i;
            oe_bits[TOT-1-nrise]   = mdio_oe;
         end
         nrise = nrise + 1;
      end
      if (!mdc && prev_mdc) idx = idx + 1;
      if (mdc && prev_mdc && mdio_o != prev_o) hi_chg = hi_chg + 1;
      prev_mdc = mdc;
      prev_o = mdio_o;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [TOT-1:0] exp_wire(input logic [31:0] f);
      return {32'hFFFF_FFFF, f};
   endfunction

   function automatic logic [TOT-1:0] exp_oe(input logic [31:0] f);
      if (f[29:28] == 2'b10) return {{47{1'b1}}, 17'd0};
      return {TOT{1'b1}};
   endfunction

   function automatic logic [31:0] exp_data(input logic [31:0] f, input logic [15:0] r);
      if (f[29:28] == 2'b10) return {f[31:16], r};
      return f;
   endfunction

   task automatic arm(input logic [31:0] f, input logic [15:0] reply, input int div);
      phy_read = f[29:28] == 2'b10;
      phy_reply = reply;
      exp_gap = 2 * div;
      idx = 0; nrise = 0; gap_err = 0; hi_chg = 0;
   endtask

   task automatic wait_idle(input int limit);
      logic [31:0] ev;
      for (int i = 0; i < limit; i++) begin
         rd(2'd2, ev);
         if (!ev[1]) break;
      end
   endtask

   task automatic verify(input logic [31:0] f, input logic [15:0] reply, input string tag);
      logic [31:0] d, ev;
      check(wire_bits == exp_wire(f) | ~exp_oe(f), {"R3 wire ", tag}, wire_bits, exp_wire(f));
      check(oe_bits == exp_oe(f), {"R5 oe ", tag}, oe_bits, exp_oe(f));
      check(nrise == TOT && gap_err == 0, {"R4 mdc period ", tag}, nrise, gap_err);
      check(hi_chg == 0, {"R3 change while high ", tag}, hi_chg, 0);
      rd(2'd3, d);
      check(d == exp_data(f, reply), {"R6 data ", tag}, d, exp_data(f, reply));
      rd(2'd2, ev);
      check(ev[1:0] == 2'b01 && mgmt_irq, {"R7 done ", tag}, ev, 1);
      wr(2'd2, 32'h1);
      rd(2'd2, ev);
      check(ev[0] == 1'b0 && !mgmt_irq, {"R8 clear ", tag}, ev, 0);
   endtask

   task automatic run_frame(input logic [31:0] f, input logic [15:0] reply, input int div, input string tag);
      logic [31:0] ev;
      wr(2'd1, 32'(div) << 1);
      arm(f, reply, div);
      wr(2'd3, f);
      rd(2'd2, ev);
      check(ev[1] == 1'b1, {"R2 busy ", tag}, ev, 2);
      wait_idle(200 * div + 200);
      // wire bits where the PHY drives are masked in the compare
      wire_bits = wire_bits | ~exp_oe(f);
      verify(f, reply, tag);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d, ev, f, f2;
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         check(d == 0, "R1 reset reg", d, 0);
      end
      check(!mdc && !mdio_oe && !mgmt_irq, "R1 reset pins", {mdc, mdio_oe, mgmt_irq}, 0);

      // R11 disabled write
      wr(2'd1, 32'd2 << 1);
      wr(2'd3, 32'h5002_1234);
      rd(2'd2, ev);
      check(ev[1] == 0, "R11 no start", ev, 0);
      rd(2'd3, d);
      check(d == 0, "R11 reg kept", d, 0);

      // R12 speed masking
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, d);
      check(d == 32'h0000_007E, "R12 speed mask", d, 32'h7E);

      wr(2'd0, 32'h1);

      // directed frames
      run_frame(32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18), 16'hA5C3, 1, "read div1");
      run_frame(32'h5002_BEEF | (32'd31 << 23), 16'h0, 3, "write div3");
      run_frame(32'h6002_0000 | (32'd17 << 18), 16'h8001, 63, "read div63");

      // R9 divider zero parks the frame
      wr(2'd1, 32'd0);
      f = 32'h6002_0000 | (32'd5 << 23);
      arm(f, 16'h3C5A, 2);
      wr(2'd3, f);
      repeat (300) @(negedge clk);
      rd(2'd2, ev);
      check(ev[1] == 1 && nrise == 0 && !mdc, "R9 parked", {ev[1], 8'(nrise)}, 32'h100);
      wr(2'd1, 32'd2 << 1);
      wait_idle(2000);
      wire_bits = wire_bits | ~exp_oe(f);
      verify(f, 16'h3C5A, "R9 resumed");

      // R10 write while busy
      wr(2'd1, 32'd2 << 1);
      f = 32'h5002_0F0F | (32'd9 << 23);
      f2 = 32'h6002_0000;
      arm(f, 16'h0, 2);
      wr(2'd3, f);
      repeat (20) @(negedge clk);
      wr(2'd3, f2);
      wait_idle(2000);
      wire_bits = wire_bits | ~exp_oe(f);
      verify(f, 16'h0, "R10 busy write");

      // R8 writing zero keeps done
      run_frame(32'h5002_0001, 16'h0, 1, "pre-keep");
      f = 32'h5002_7777;
      wr(2'd1, 32'd1 << 1);
      arm(f, 16'h0, 1);
      wr(2'd3, f);
      wait_idle(1000);
      wr(2'd2, 32'h0);
      rd(2'd2, ev);
      check(ev[0] == 1 && mgmt_irq, "R8 zero keeps", ev, 1);
      wr(2'd2, 32'h1);

      // random frames
      for (int n = 0; n < 10; n++) begin
         logic [31:0] rf;
         logic [15:0] rr;
         int dv;
         rf = ($urandom() & 1) ? 32'h6002_0000 : 32'h5002_0000;
         rf = rf | (32'($urandom() & 31) << 23) | (32'($urandom() & 31) << 18);
         if (rf[29:28] == 2'b01) rf[15:0] = 16'($urandom());
         rr = 16'($urandom());
         dv = 1 + int'($urandom() % 4);
         run_frame(rf, rr, dv, "random");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule